// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a pipelined synchronous SRAM that never needs idle cycles when reads and writes are mixed. A command and an address are taken on each enabled rising edge. Read data comes out of an output register two enabled edges later. Write data is taken on the bus two enabled edges after its address, which is the same delay as a read. Any order of reads and writes therefore moves one data word per clock.

A clock enable stalls every stage at once. Three synchronous chip selects qualify each load. An advance/load control either starts a new access or steps a four-beat burst, in linear or interleaved order. Per-byte write selects choose which lanes of the word are changed. The block has separate read and write data buses. A drive flag shows when the read bus would be driven. The flag is turned off during each write data phase and whenever the asynchronous output enable is inactive.

Top module: `zt_sram`

## Requirements
- R1: A selected load with `we_n`=1 sampled on an enabled edge puts the stored word on `rdata` after the second following enabled edge. `rdata_oe` is 1 in that cycle.
- R2: A selected load with `we_n`=0 stores `wdata` as it is sampled on the second enabled edge after the address. Only lanes whose bit in `be_n` was 0 at address time are changed. Bit i of `be_n` selects bits 8i+7..8i.
- R3: Reads and writes may follow one another on consecutive edges in any order. A read issued on the edge after a write to the same word returns the merged new and old bytes.
- R4: While `ce`=0, edges are ignored. `rdata`, `rdata_oe`, the burst state and the memory all hold, and `wdata` has no effect.
- R5: A load is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other load is a deselect: it writes nothing, and `rdata_oe` is 0 after the second following enabled edge.
- R6: In the cycle that follows the edge taking a write's data, `rdata_oe` is 0.
- R7: When `oe_n`=1, `rdata_oe` is 0 at once, without waiting for a clock edge. When `oe_n` returns to 0, the registered drive state shows again at once.
- R8: With `ilv`=0, each `adv_ld`=1 edge issues the next burst beat. The beat uses the command type of the last load and the current `be_n`. Address bits 1..0 are (start + n) mod 4, where n is the beat number 1..3. The upper bits are those of the loaded address.
- R9: With `ilv`=1, advanced beats use address bits 1..0 equal to start XOR n.
- R10: An advance that follows a deselect load issues nothing. The advance ignores the chip selects and `we_n`.
- R11: After reset, `rdata_oe` is 0, no access is pending, and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline state |
| ce | input | 1 | Clock enable, active high |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write command on a load, active low |
| be_n | input | NB | Byte-lane write selects, active low |
| adv_ld | input | 1 | 1 steps the burst, 0 loads a new address |
| ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | Word address |
| wdata | input | NB*BW | Write data bus |
| rdata | output | NB*BW | Registered read data |
| rdata_oe | output | 1 | Read bus drive flag |

## Verification
The assertions assume that `ce`, the commands and `wdata` change only away from the rising edge. They also assume that `oe_n` stays at 0 across the edges where the drive stage is checked. The bench drives every synchronous input on the falling edge and samples on the falling edge. It toggles `oe_n` only between edges, and returns it to 0 before the next rising edge. Every word is written before any read of it, so all expected data is known. Only the burst addresses and the chip-select combinations are taken outside the plain load path.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int DW = NB * BW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          cs1_n,
  input  logic          cs2,
  input  logic          cs3_n,
  input  logic          we_n,
  input  logic [NB-1:0] be_n,
  input  logic          adv_ld,
  input  logic          ilv,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe
);

  logic [DW-1:0] mem [DEPTH];

  logic          b_act, b_wr;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;

  logic          s1_v, s1_wr, s2_v, s2_wr;
  logic [AW-1:0] s1_a, s2_a;
  logic [NB-1:0] s1_be, s2_be;
  logic          oe_q;
  logic [DW-1:0] rdata_q;

  wire           sel      = !cs1_n && cs2 && !cs3_n;
  wire [1:0]     nxt_cnt  = b_cnt + 2'd1;
  wire [1:0]     beat_lo  = ilv ? (b_base[1:0] ^ nxt_cnt) : (b_base[1:0] + nxt_cnt);
  wire           issue_v  = adv_ld ? b_act : sel;
  wire           issue_wr = adv_ld ? b_wr : !we_n;
  wire [AW-1:0]  issue_a  = adv_ld ? {b_base[AW-1:2], beat_lo} : addr;
  wire           s2_rd    = s2_v && !s2_wr;
  wire           commit   = ce && s2_v && s2_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_act   <= 1'b0;
      b_wr    <= 1'b0;
      b_base  <= '0;
      b_cnt   <= '0;
      s1_v    <= 1'b0;
      s1_wr   <= 1'b0;
      s1_a    <= '0;
      s1_be   <= '1;
      s2_v    <= 1'b0;
      s2_wr   <= 1'b0;
      s2_a    <= '0;
      s2_be   <= '1;
      oe_q    <= 1'b0;
      rdata_q <= '0;
    end else if (ce) begin
      if (!adv_ld) begin
        b_act  <= sel;
        b_wr   <= !we_n;
        b_base <= addr;
        b_cnt  <= '0;
      end else if (b_act) begin
        b_cnt  <= nxt_cnt;
      end
      s1_v  <= issue_v;
      s1_wr <= issue_wr;
      s1_a  <= issue_a;
      s1_be <= be_n;
      s2_v  <= s1_v;
      s2_wr <= s1_wr;
      s2_a  <= s1_a;
      s2_be <= s1_be;
      oe_q  <= s2_rd;
      if (s2_rd) rdata_q <= mem[s2_a];
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < NB; i++) begin
        if (!s2_be[i]) mem[s2_a][i*BW +: BW] <= wdata[i*BW +: BW];
      end
    end
  end

  assign rdata    = rdata_q;
  assign rdata_oe = oe_q && !oe_n;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce,
  input logic          adv_ld,
  input logic [DW-1:0] rdata,
  input logic          rdata_oe,
  input logic          b_act,
  input logic          s1_v,
  input logic          s2_v,
  input logic          s2_wr,
  input logic          oe_q
);

  a_r6_off_in_write_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && s2_v && s2_wr) |=> !rdata_oe);

  a_r1_drive_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && s2_v && !s2_wr) |=> oe_q);

  a_r5_deselect_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !s2_v) |=> !oe_q);

  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(rdata) && $stable(oe_q) && $stable(s1_v) && $stable(s2_v)));

  a_r10_adv_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && adv_ld && !b_act) |=> !s1_v);

endmodule

bind zt_sram zt_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .adv_ld(adv_ld), .rdata(rdata),
  .rdata_oe(rdata_oe), .b_act(b_act), .s1_v(s1_v), .s2_v(s2_v),
  .s2_wr(s2_wr), .oe_q(oe_q)
);

// File: tb/zt_sram_bench.sv
module zt_sram_bench;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n, ce, cs1_n, cs2, cs3_n, we_n, adv_ld, ilv, oe_n;
  logic [NB-1:0] be_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic rdata_oe;

  zt_sram u_zt_sram (
    .clk(clk), .rst_n(rst_n), .ce(ce), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .we_n(we_n), .be_n(be_n), .adv_ld(adv_ld), .ilv(ilv), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R11";

  logic [DW-1:0] model [64];
  logic [31:0] lf = 32'h1234_5679;

  logic m_act, m_wr;
  logic [AW-1:0] m_base;
  logic [1:0] m_cnt;
  logic p1_v, p1_wr, p2_v, p2_wr;
  logic [AW-1:0] p1_a, p2_a;
  logic [NB-1:0] p1_be, p2_be;
  logic exp_oe, last_w;
  logic [DW-1:0] exp_d;

  function automatic logic [31:0] rnd();
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    return lf;
  endfunction

  task automatic check(string r, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic step(bit c, bit [2:0] cs, bit w, bit [NB-1:0] be, bit adv,
                      bit il, bit [AW-1:0] a, bit [DW-1:0] d);
    logic sel, iv, iw;
    logic [AW-1:0] ia;
    logic [1:0] n;
    ce = c; {cs3_n, cs2, cs1_n} = cs; we_n = w; be_n = be; adv_ld = adv;
    ilv = il; addr = a; wdata = d;
    @(posedge clk);
    if (c) begin
      if (p2_v && p2_wr) begin
        for (int i = 0; i < NB; i++)
          if (!p2_be[i]) model[p2_a][i*8 +: 8] = d[i*8 +: 8];
        exp_oe = 0; last_w = 1;
      end else if (p2_v) begin
        exp_d = model[p2_a]; exp_oe = 1; last_w = 0;
      end else begin
        exp_oe = 0; last_w = 0;
      end
      sel = (cs == 3'b010);
      iv = 0; iw = 0; ia = a;
      if (!adv) begin
        iv = sel; iw = !w;
        m_act = sel; m_wr = !w; m_base = a; m_cnt = 0;
      end else if (m_act) begin
        m_cnt = m_cnt + 2'd1; n = m_cnt;
        iv = 1; iw = m_wr;
        ia = {m_base[AW-1:2], il ? (m_base[1:0] ^ n) : (m_base[1:0] + n)};
      end
      p2_v = p1_v; p2_wr = p1_wr; p2_a = p1_a; p2_be = p1_be;
      p1_v = iv; p1_wr = iw; p1_a = ia; p1_be = be;
    end
    @(negedge clk);
    check(last_w ? "R6" : tag, {31'd0, rdata_oe}, {31'd0, exp_oe & !oe_n});
    if (exp_oe && !oe_n) check(tag, rdata, exp_d);
  endtask

  task automatic wr(bit [AW-1:0] a, bit [DW-1:0] d, bit [NB-1:0] be);
    step(1, 3'b010, 0, be, 0, 0, a, d);
  endtask
  task automatic rd(bit [AW-1:0] a);
    step(1, 3'b010, 1, 4'hF, 0, 0, a, rnd());
  endtask
  task automatic nop();
    step(1, 3'b000, 1, 4'hF, 0, 0, 0, rnd());
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ce = 1; cs1_n = 1; cs2 = 0; cs3_n = 1; we_n = 1; be_n = '1;
    adv_ld = 0; ilv = 0; oe_n = 0; addr = 0; wdata = 0;
    m_act = 0; m_wr = 0; m_base = 0; m_cnt = 0;
    p1_v = 0; p1_wr = 0; p1_a = 0; p1_be = '1; p2_v = 0; p2_wr = 0; p2_a = 0; p2_be = '1;
    exp_oe = 0; last_w = 0; exp_d = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11", {31'd0, rdata_oe}, 32'd0);

    tag = "R2";
    for (int a = 0; a < 64; a++) wr(a[AW-1:0], (a * 32'h0101_0101) ^ 32'hA500_3C00, 4'h0);
    tag = "R1";
    for (int a = 0; a < 64; a++) rd(a[AW-1:0]);
    nop(); nop(); nop();

    tag = "R2";
    for (int m = 0; m < 16; m++) begin
      wr(7, {4{m[3:0], 4'hC}} ^ rnd(), m[NB-1:0]);
      nop(); nop(); rd(7); nop(); nop();
    end

    tag = "R3";
    for (int i = 0; i < 40; i++) begin
      wr(i[2:0] + 6'd8, rnd(), rnd() & 4'hF);
      rd(i[2:0] + 6'd8);
      if (i % 3 == 0) rd(i[2:0] + 6'd9);
    end
    nop(); nop();

    tag = "R4";
    for (int i = 0; i < 80; i++) begin
      logic [31:0] r;
      r = rnd();
      step(r[0] | r[1], 3'b010, r[2], r[7:4], 0, 0, {3'd2, r[10:8]}, rnd());
    end
    nop(); nop();

    tag = "R5";
    for (int c = 0; c < 8; c++) begin
      step(1, c[2:0], 0, 4'h0, 0, 0, 9, rnd());
      nop(); nop(); rd(9); nop(); nop();
      step(1, c[2:0], 1, 4'hF, 0, 0, 9, rnd());
      nop(); nop();
    end

    for (int il = 0; il < 2; il++) begin
      tag = il ? "R9" : "R8";
      for (int s = 0; s < 4; s++) begin
        step(1, 3'b010, 0, 4'h0, 0, il[0], 6'd32 + s[5:0], rnd());
        for (int b = 1; b < 4; b++) step(1, 3'b111, 1, 4'h0, 1, il[0], 0, rnd());
        nop(); nop();
        for (int k = 0; k < 4; k++) rd(6'd32 + k[5:0]);
        step(1, 3'b010, 1, 4'hF, 0, il[0], 6'd32 + s[5:0], rnd());
        for (int b = 1; b < 4; b++) step(1, 3'b000, 0, 4'h0, 1, il[0], 0, rnd());
        nop(); nop();
      end
    end

    tag = "R10";
    step(1, 3'b011, 0, 4'h0, 0, 0, 40, rnd());
    step(1, 3'b010, 0, 4'h0, 1, 0, 40, rnd());
    step(1, 3'b010, 0, 4'h0, 1, 0, 40, rnd());
    nop(); nop();
    for (int k = 40; k < 44; k++) rd(k[AW-1:0]);
    nop(); nop();

    tag = "R7";
    for (int i = 0; i < 8; i++) begin
      rd(i[AW-1:0]);
      oe_n = 1; #1;
      check("R7", {31'd0, rdata_oe}, 32'd0);
      oe_n = 0; #1;
      check("R7", {31'd0, rdata_oe}, {31'd0, exp_oe});
    end
    nop(); nop();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule